// File: doc/BRIEF.md
# DTMF Steering Validator and Key Latch

This block sits behind a dual-tone classifier. The classifier reports a level flag that is high while a legal row/column tone pair is heard, plus the row and column indices of that pair. The block replaces an analogue RC steering network with digital timing. The flag must stay high for a programmable tone-present guard time before the pair is accepted. On acceptance, a 4-bit key code is written into a holding register, and one clock later a held-tone output rises. The held-tone output is released only after the flag has stayed low for a separate, programmable tone-absent guard time. Short flag dropouts therefore do not split one key press into two.

Both guard times are given in milliseconds. The timing uses a millisecond prescaler that runs from the system clock, so that a guard of G ms needs G × CLK_PER_MS consecutive clock edges. A block input can stop registration of the fourth tone column. An output enable either drives the held code or parks the data lines with their valid mask cleared. A power-down input returns the timing logic to idle.

Top module: `dtmf_steer_top`

## Requirements
- R1: After synchronous reset, the held code is 0 and `held_o` is low.
- R2: While `held_o` is low and `pwrdn_i` is low, suppose `early_i` is sampled high with a non-blocked pair on N = `present_ms_i` × CLK_PER_MS consecutive rising edges. Then the code of the pair sampled on the N-th edge is latched on that edge, and `held_o` rises on the following edge.
- R3: A burst of `early_i` that is shorter than N edges leaves the code and `held_o` unchanged.
- R4: Once `held_o` is high, it falls on the M-th consecutive edge at which `early_i` is sampled low, where M = `absent_ms_i` × CLK_PER_MS.
- R5: A low period of `early_i` shorter than M edges while `held_o` is high keeps `held_o` high and the code unchanged. The absent count restarts when `early_i` returns high.
- R6: The held code keeps its value after `held_o` falls, and it changes only when the next pair is registered. It never changes while `held_o` is high.
- R7: Row index 0..3 selects the low tone, from lowest to highest. Column index 0..3 selects the high tone, from lowest to highest. The codes are as follows.
  - Rows 0..2 with columns 0..2 are digits 1..9, with code = row×3 + col + 1.
  - Row 3 gives code 11 at column 0 (star), 10 at column 1 (digit 0) and 12 at column 2 (hash).
  - Column 3 gives codes 13, 14 and 15 at rows 0, 1 and 2, and code 0 at row 3.
- R8: The tone-present and tone-absent guard times are independent inputs, and each sets only its own window.
- R9: With `oe_i` high, `code_o` shows the held code and `code_vld_o` is 4'b1111. With `oe_i` low, both are 0.
- R10: The new code appears at `code_o` exactly one clock before `held_o` rises.
- R11: While `col4_block_i` is high, a pair with column index 3 is never registered, however long it lasts. Pairs in other columns register normally.
- R12: While `pwrdn_i` is high, nothing is registered and `held_o` goes low on the next edge. A guard run that was in progress is discarded. The held code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| early_i | input | 1 | Level flag from the classifier: a valid tone pair is present |
| row_i | input | 2 | Low-tone row index of the current pair |
| col_i | input | 2 | High-tone column index of the current pair |
| present_ms_i | input | GT_W | Tone-present guard time in ms |
| absent_ms_i | input | GT_W | Tone-absent guard time in ms |
| col4_block_i | input | 1 | Blocks registration of column-3 pairs |
| oe_i | input | 1 | Output enable for the code lines |
| pwrdn_i | input | 1 | Power-down: stops detection, returns to idle |
| code_o | output | 4 | Held key code (0 when disabled) |
| code_vld_o | output | 4 | Per-bit drive mask (all ones when enabled) |
| held_o | output | 1 | Held-tone (delayed steering) output |

## Verification
Exact-length bursts of N edges are compared against bursts of N−1 edges, which separates correct registration from an off-by-one in the prescaler or the millisecond count. Dropouts of M−1 and of M low edges separate tolerance of a dropout from the end of the tone. A walk over all sixteen pairs checks every code. Blocked column-3 pairs, together with a blocked-state column-0 pair, show that the block input acts on one column only. Power-down applied part-way through a guard run shows that the run is discarded rather than paused. Seeded random keys, burst lengths and block settings then run against the bench's own code function.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LATCH = 2'd1,
    ST_HELD  = 2'd2
  } steer_st_e;

  // Row 0..3 = low tones ascending, column 0..3 = high tones ascending.
  function automatic logic [3:0] pair_to_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] v;
    if (col == 2'd3) begin
      v = (row == 2'd3) ? 4'd0 : 4'd13 + {2'b00, row};
    end else if (row == 2'd3) begin
      case (col)
        2'd0:    v = 4'd11;
        2'd1:    v = 4'd10;
        default: v = 4'd12;
      endcase
    end else begin
      v = ({2'b00, row} * 4'd3) + {2'b00, col} + 4'd1;
    end
    return v;
  endfunction

endpackage

// File: rtl/steer_prescale.sv
module steer_prescale #(
  parameter int CLK_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick_o
);
  localparam int PW = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run && (pre_q == LAST);

endmodule

// File: rtl/steer_guard_cnt.sv
module steer_guard_cnt #(
  parameter int GT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            run,
  input  logic            tick,
  input  logic [GT_W-1:0] limit,
  output logic            done_o
);
  localparam int EW = GT_W + 1;

  logic [GT_W-1:0] ms_q;
  logic [EW-1:0]   ms_next;

  assign ms_next = {1'b0, ms_q} + EW'(1);
  assign done_o  = run && ((limit == '0) || (tick && (ms_next >= {1'b0, limit})));

  always_ff @(posedge clk) begin
    if (rst || clr || !run)         ms_q <= '0;
    else if (tick && (ms_q != '1))  ms_q <= ms_q + 1'b1;
  end

endmodule

// File: rtl/dtmf_steer_top.sv
module dtmf_steer_top
  import dtmf_steer_pkg::*;
#(
  parameter int CLK_PER_MS = 50000,
  parameter int GT_W       = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            early_i,
  input  logic [1:0]      row_i,
  input  logic [1:0]      col_i,
  input  logic [GT_W-1:0] present_ms_i,
  input  logic [GT_W-1:0] absent_ms_i,
  input  logic            col4_block_i,
  input  logic            oe_i,
  input  logic            pwrdn_i,
  output logic [3:0]      code_o,
  output logic [3:0]      code_vld_o,
  output logic            held_o
);
  localparam int NCH = 2;  // channel 0: tone present, channel 1: tone absent

  steer_st_e       st_q;
  logic [3:0]      code_q;
  logic            held_q;
  logic            pair_ok;
  logic [NCH-1:0]  run_w;
  logic [NCH-1:0]  tick_w;
  logic [NCH-1:0]  done_w;
  logic [GT_W-1:0] lim_w [NCH];

  assign pair_ok  = !(col4_block_i && (col_i == 2'd3));
  assign run_w[0] = !pwrdn_i && (st_q == ST_IDLE) && early_i && pair_ok;
  assign run_w[1] = !pwrdn_i && (st_q == ST_HELD) && !early_i;
  assign lim_w[0] = present_ms_i;
  assign lim_w[1] = absent_ms_i;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_guard
    steer_prescale #(.CLK_PER_MS(CLK_PER_MS)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .clr    (done_w[gi]),
      .run    (run_w[gi]),
      .tick_o (tick_w[gi])
    );
    steer_guard_cnt #(.GT_W(GT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .clr    (done_w[gi]),
      .run    (run_w[gi]),
      .tick   (tick_w[gi]),
      .limit  (lim_w[gi]),
      .done_o (done_w[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      held_q <= 1'b0;
      code_q <= 4'd0;
    end else if (pwrdn_i) begin
      st_q   <= ST_IDLE;
      held_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (done_w[0]) begin
            code_q <= pair_to_code(row_i, col_i);
            st_q   <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          st_q   <= ST_HELD;
          held_q <= 1'b1;
        end
        default: begin
          if (done_w[1]) begin
            st_q   <= ST_IDLE;
            held_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign code_o     = oe_i ? code_q : 4'd0;
  assign code_vld_o = {4{oe_i}};
  assign held_o     = held_q;

  // R10: a fresh code is followed by the held output on the next edge
  assert_code_lead_R10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(code_q) && !pwrdn_i) |=> held_q);

  // R6: the held code never moves while a tone is held
  assert_code_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    held_q |-> $stable(code_q));

  // R11: a blocked column-3 pair is never latched
  assert_block_col_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_q) |-> !($past(col4_block_i) && ($past(col_i) == 2'd3)));

  // R12: power-down drops the held output and keeps the code
  assert_pwrdn_idle_R12: assert property (@(posedge clk) disable iff (rst)
    pwrdn_i |=> (!held_q && $stable(code_q)));

  // R4: the held output only falls after a low flag or power-down
  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(held_q) |-> ($past(!early_i) || $past(pwrdn_i)));

  // R2: a latch event requires the flag to have been high
  assert_latch_flag_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_q) |-> $past(early_i));

endmodule

// File: tb/dtmf_steer_top_tb_top.sv
module dtmf_steer_top_tb_top;
  localparam int CPM  = 8;
  localparam int GT_W = 8;
  localparam int PMS  = 3;
  localparam int AMS  = 2;
  localparam int N    = PMS * CPM;
  localparam int M    = AMS * CPM;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            early_i = 1'b0;
  logic [1:0]      row_i = 2'd0;
  logic [1:0]      col_i = 2'd0;
  logic [GT_W-1:0] present_ms_i = GT_W'(PMS);
  logic [GT_W-1:0] absent_ms_i  = GT_W'(AMS);
  logic            col4_block_i = 1'b0;
  logic            oe_i = 1'b1;
  logic            pwrdn_i = 1'b0;
  logic [3:0]      code_o;
  logic [3:0]      code_vld_o;
  logic            held_o;

  int total = 0;
  int bad   = 0;
  logic [3:0] prev;

  always #10 clk = ~clk;

  dtmf_steer_top #(.CLK_PER_MS(CPM), .GT_W(GT_W)) dut_i (
    .clk(clk), .rst(rst), .early_i(early_i), .row_i(row_i), .col_i(col_i),
    .present_ms_i(present_ms_i), .absent_ms_i(absent_ms_i),
    .col4_block_i(col4_block_i), .oe_i(oe_i), .pwrdn_i(pwrdn_i),
    .code_o(code_o), .code_vld_o(code_vld_o), .held_o(held_o)
  );

  function automatic logic [3:0] ref_code(input logic [1:0] r, input logic [1:0] c);
    case ({r, c})
      4'b0000: return 4'd1;   4'b0001: return 4'd2;
      4'b0010: return 4'd3;   4'b0011: return 4'd13;
      4'b0100: return 4'd4;   4'b0101: return 4'd5;
      4'b0110: return 4'd6;   4'b0111: return 4'd14;
      4'b1000: return 4'd7;   4'b1001: return 4'd8;
      4'b1010: return 4'd9;   4'b1011: return 4'd15;
      4'b1100: return 4'd11;  4'b1101: return 4'd10;
      4'b1110: return 4'd12;  default: return 4'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Full register/release cycle with edge-exact checks.
  task automatic reg_cycle(input logic [1:0] r, input logic [1:0] c,
                           input int n, input int m, input logic [3:0] old);
    @(negedge clk); row_i = r; col_i = c; early_i = 1'b1;
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    chk("R3 one edge short, code", 32'(code_o), 32'(old));
    @(posedge clk); @(negedge clk);
    chk("R10 code early", 32'(code_o), 32'(ref_code(r, c)));
    chk("R10 held still low", 32'(held_o), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 held rises", 32'(held_o), 1);
    early_i = 1'b0;
    repeat (m - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 held before last low edge", 32'(held_o), 1);
    @(posedge clk); @(negedge clk);
    chk("R4 held released", 32'(held_o), 0);
    chk("R6 code kept after release", 32'(code_o), 32'(ref_code(r, c)));
  endtask

  task automatic burst(input logic [1:0] r, input logic [1:0] c, input int n);
    @(negedge clk); row_i = r; col_i = c; early_i = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); early_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 reset code", 32'(code_o), 0);
    chk("R1 reset held", 32'(held_o), 0);
    prev = 4'd0;

    // R2 R10 R4 basic register and release
    reg_cycle(2'd1, 2'd1, N, M, prev); prev = 4'd5;

    // R3 short burst rejected
    burst(2'd2, 2'd2, N - 1);
    repeat (M + 2) @(posedge clk); @(negedge clk);
    chk("R3 short burst code", 32'(code_o), 32'(prev));
    chk("R3 short burst held", 32'(held_o), 0);

    // R5 dropout tolerated, then real release
    @(negedge clk); row_i = 2'd0; col_i = 2'd1; early_i = 1'b1;
    repeat (N + 2) @(posedge clk);
    @(negedge clk); early_i = 1'b0;
    repeat (M - 1) @(posedge clk);
    @(negedge clk); early_i = 1'b1;
    chk("R5 dropout held", 32'(held_o), 1);
    repeat (3) @(posedge clk);
    @(negedge clk); early_i = 1'b0;
    repeat (M - 1) @(posedge clk); @(negedge clk);
    chk("R5 count restarted", 32'(held_o), 1);
    chk("R5 code latched", 32'(code_o), 2);
    @(posedge clk); @(negedge clk);
    chk("R4 release after full gap", 32'(held_o), 0);
    prev = 4'd2;

    // R9 output enable
    oe_i = 1'b0; #1;
    chk("R9 disabled code", 32'(code_o), 0);
    chk("R9 disabled mask", 32'(code_vld_o), 0);
    oe_i = 1'b1; #1;
    chk("R9 enabled code", 32'(code_o), 32'(prev));
    chk("R9 enabled mask", 32'(code_vld_o), 32'hF);

    // R8 independent guard times
    present_ms_i = GT_W'(1); absent_ms_i = GT_W'(5);
    reg_cycle(2'd3, 2'd2, CPM, 5 * CPM, prev); prev = 4'd12;
    chk("R8 hash with 1ms/5ms guards", 32'(code_o), 12);
    present_ms_i = GT_W'(PMS); absent_ms_i = GT_W'(AMS);

    // R11 column block
    col4_block_i = 1'b1;
    @(negedge clk); row_i = 2'd0; col_i = 2'd3; early_i = 1'b1;
    repeat (2 * N) @(posedge clk); @(negedge clk);
    chk("R11 blocked held", 32'(held_o), 0);
    chk("R11 blocked code", 32'(code_o), 32'(prev));
    early_i = 1'b0;
    repeat (4) @(posedge clk);
    reg_cycle(2'd0, 2'd0, N, M, prev); prev = 4'd1;
    chk("R11 other column passes", 32'(code_o), 1);
    col4_block_i = 1'b0;

    // R12 power-down discards a partial run
    @(negedge clk); row_i = 2'd2; col_i = 2'd0; early_i = 1'b1;
    repeat (N / 2) @(posedge clk);
    @(negedge clk); pwrdn_i = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); pwrdn_i = 1'b0;
    repeat (N - 1) @(posedge clk); @(negedge clk);
    chk("R12 partial run discarded", 32'(code_o), 32'(prev));
    @(posedge clk); @(negedge clk);
    chk("R12 fresh run registers", 32'(code_o), 7);
    @(posedge clk); @(negedge clk);
    chk("R12 held up", 32'(held_o), 1);
    pwrdn_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R12 held dropped", 32'(held_o), 0);
    chk("R12 code kept", 32'(code_o), 7);
    early_i = 1'b0; pwrdn_i = 1'b0;
    prev = 4'd7;
    repeat (3) @(posedge clk);

    // R7 every pair
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        reg_cycle(2'(r), 2'(c), N, M, prev);
        prev = ref_code(2'(r), 2'(c));
        chk("R7 pair code", 32'(code_o), 32'(prev));
      end
    end

    // Random keys, lengths and block setting
    for (int k = 0; k < 40; k++) begin
      logic [1:0] rr, cc;
      logic blk, lng;
      int len;
      rr = 2'($urandom % 4);
      cc = 2'($urandom % 4);
      blk = 1'($urandom % 2);
      lng = 1'($urandom % 2);
      len = lng ? N + int'($urandom % N) : 1 + int'($urandom % (N - 1));
      col4_block_i = blk;
      burst(rr, cc, len);
      repeat (M + 3) @(posedge clk); @(negedge clk);
      if (lng && !(blk && cc == 2'd3)) prev = ref_code(rr, cc);
      chk(lng ? "R2 R11 random long" : "R3 random short", 32'(code_o), 32'(prev));
      chk("R4 random released", 32'(held_o), 0);
    end
    col4_block_i = 1'b0;

    finish_run();
  end

endmodule